// File: doc/BRIEF.md
# Prescaled Single-Channel Pulse-Width Modulator

This block produces one pulse-width-modulated output from a fast input clock. The clock is first slowed by a two-stage prescaler. The first stage is a linear divide by (N+1) with an 8-bit N. The second stage is a power-of-two shift set by a 4-bit exponent. Each prescaled tick advances an 8-bit period counter that counts up to a programmable top value and then wraps. The output level is taken from where the counter sits relative to two programmable compare points. The output is high from the "on" point up to, but not including, the "off" point, and this window may wrap around the end of the period. When the two points are equal, the output is high for the whole period.

Software programs the block through a write-only port that holds two words. The control word holds the divider fields, two enables, the polarity and the reload-mode bit. The timing word holds the period top and the two compare points. Divider, period and compare values reach the running waveform through shadow copies. In the default mode the shadows reload only at a period boundary. When the reload-mode bit is set, the shadows follow the written values on the clock after each write. Polarity and the enables never pass through the shadows. A change to any of them reaches the output as soon as the word is written.

Top module: `pwm_prescaled_channel`

## Requirements
- R1: After reset `pwm_out` is low and stays low until a control word with both enables set is written.
- R2: A control word is written with `wr_addr`=0 and a timing word with `wr_addr`=1. Control word fields: linear divider N in bits 7:0, shift exponent S in bits 11:8, output enable in bit 12, polarity in bit 14, count enable in bit 16, immediate-reload mode in bit 17. Timing word fields: on point in bits 7:0, off point in bits 15:8, period top P in bits 31:24. One period lasts (N+1)·2^S·(P+1) input clock cycles, and each counter value is held for (N+1)·2^S cycles.
- R3: The counter counts from 0 to P and wraps to 0. With polarity bit 0, the output is high while the count lies in the window from the on point to the off point, excluding the off point. The window wraps past P when the on point is greater than the off point.
- R4: When the on point equals the off point, the output stays high for every cycle of the period.
- R5: While the output enable is 0, `pwm_out` is low whatever the other settings are. Clearing the output enable drives the output low right after the write edge, without finishing the current period.
- R6: While the count enable is 0, the counter and prescaler are held at 0 and `pwm_out` is low. Timing values written during this time are used from the first cycle after the count enable is set. At that point the count starts at 0.
- R7: A write that changes the polarity bit inverts `pwm_out` right after the write edge, without waiting for a period boundary.
- R8: With the reload-mode bit at 0, new divider, period and compare values written while the counter runs take effect only when the counter wraps to 0. The period in progress completes with the old values.
- R9: With the reload-mode bit at 1, newly written divider, period and compare values take effect on the clock edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, rising-edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_addr | input | 1 | 0 selects the control word, 1 the timing word |
| wr_data | input | 32 | Word to write |
| pwm_out | output | 1 | Modulated output |

## Verification
A timing-word write can arrive in the same cycle that the counter is partway through a period. The reload mode then decides whether the running pulse is cut short or completes with the old off point. The bench writes a new, earlier off point ten counts into a 100-count period, once in each mode. It judges the result by the lengths of the high and low runs it sees at the pin: 39/50/20 in the deferred mode and 9/80/20 in the immediate mode. A polarity write also lands while the counter is running. The bench checks that the output flips on the very next sample regardless of the counter phase.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  // Write port word selector
  typedef enum logic {
    SEL_CTRL   = 1'b0,
    SEL_TIMING = 1'b1
  } pwm_sel_e;

  // Control word bit positions
  localparam int CTL_DIVL_LSB = 0;
  localparam int CTL_DIVH_LSB = 8;
  localparam int CTL_OUT_EN   = 12;
  localparam int CTL_INVERT   = 14;
  localparam int CTL_RUN_EN   = 16;
  localparam int CTL_IMM_LOAD = 17;

  // Timing word bit positions
  localparam int TIM_ON_LSB   = 0;
  localparam int TIM_OFF_LSB  = 8;
  localparam int TIM_TOP_LSB  = 24;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int DIVL_W = 8,
  parameter int DIVH_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [DIVL_W-1:0] div_lin,
  input  logic [DIVH_W-1:0] div_shift,
  output logic              tick
);
  localparam int PRE_W = DIVL_W + (1 << DIVH_W) - 1;

  // Last prescaler count before a tick: (N+1)*2^S - 1
  function automatic logic [PRE_W-1:0] tick_limit(
    input logic [DIVL_W-1:0] n,
    input logic [DIVH_W-1:0] s
  );
    logic [PRE_W:0] span;
    span = ({{(PRE_W-DIVL_W){1'b0}}, 1'b0, n} + 1'b1) << s;
    return PRE_W'(span - 1'b1);
  endfunction

  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] limit;

  assign limit = tick_limit(div_lin, div_shift);
  assign tick  = run && (pre_cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pre_cnt <= '0;
    else if (!run)       pre_cnt <= '0;
    else if (tick)       pre_cnt <= '0;
    else                 pre_cnt <= pre_cnt + 1'b1;
  end

  // R6
  pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pre_cnt == '0));
endmodule

// File: rtl/pwm_period_counter.sv
module pwm_period_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] top,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  assign wrap = tick && (count >= top);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (!run)  count <= '0;
    else if (wrap)  count <= '0;
    else if (tick)  count <= count + 1'b1;
  end

  // R3
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (count == '0));

  // R6
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (count == '0));
endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow #(
  parameter int DIVL_W = 8,
  parameter int DIVH_W = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DIVL_W-1:0] div_lin_w,
  input  logic [DIVH_W-1:0] div_shift_w,
  input  logic [CNT_W-1:0]  top_w,
  input  logic [CNT_W-1:0]  on_w,
  input  logic [CNT_W-1:0]  off_w,
  output logic [DIVL_W-1:0] div_lin_a,
  output logic [DIVH_W-1:0] div_shift_a,
  output logic [CNT_W-1:0]  top_a,
  output logic [CNT_W-1:0]  on_a,
  output logic [CNT_W-1:0]  off_a
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_lin_a   <= '0;
      div_shift_a <= '0;
      top_a       <= '0;
      on_a        <= '0;
      off_a       <= '0;
    end else if (load) begin
      div_lin_a   <= div_lin_w;
      div_shift_a <= div_shift_w;
      top_a       <= top_w;
      on_a        <= on_w;
      off_a       <= off_w;
    end
  end
endmodule

// File: rtl/pwm_prescaled_channel.sv
module pwm_prescaled_channel #(
  parameter int DIVL_W = 8,
  parameter int DIVH_W = 4,
  parameter int CNT_W  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_addr,
  input  logic [31:0] wr_data,
  output logic        pwm_out
);
  import pwm_pkg::*;

  // Level inside the on/off window; equal points mean always high
  function automatic logic window_level(
    input logic [CNT_W-1:0] c,
    input logic [CNT_W-1:0] on_pt,
    input logic [CNT_W-1:0] off_pt
  );
    if (on_pt == off_pt)     return 1'b1;
    else if (on_pt < off_pt) return (c >= on_pt) && (c < off_pt);
    else                     return (c >= on_pt) || (c < off_pt);
  endfunction

  // Written register state
  logic              imm_load_q, run_en_q, invert_q, out_en_q;
  logic [DIVL_W-1:0] div_lin_q;
  logic [DIVH_W-1:0] div_shift_q;
  logic [CNT_W-1:0]  top_q, on_q, off_q;

  logic wr_ctrl, wr_tim;
  assign wr_ctrl = wr_en && (pwm_sel_e'(wr_addr) == SEL_CTRL);
  assign wr_tim  = wr_en && (pwm_sel_e'(wr_addr) == SEL_TIMING);

  logic unused_wr_bits;
  assign unused_wr_bits = ^wr_data[23:18];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imm_load_q  <= 1'b0;
      run_en_q    <= 1'b0;
      invert_q    <= 1'b0;
      out_en_q    <= 1'b0;
      div_lin_q   <= '0;
      div_shift_q <= '0;
    end else if (wr_ctrl) begin
      imm_load_q  <= wr_data[CTL_IMM_LOAD];
      run_en_q    <= wr_data[CTL_RUN_EN];
      invert_q    <= wr_data[CTL_INVERT];
      out_en_q    <= wr_data[CTL_OUT_EN];
      div_lin_q   <= wr_data[CTL_DIVL_LSB +: DIVL_W];
      div_shift_q <= wr_data[CTL_DIVH_LSB +: DIVH_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q <= '0;
      on_q  <= '0;
      off_q <= '0;
    end else if (wr_tim) begin
      top_q <= wr_data[TIM_TOP_LSB +: CNT_W];
      on_q  <= wr_data[TIM_ON_LSB  +: CNT_W];
      off_q <= wr_data[TIM_OFF_LSB +: CNT_W];
    end
  end

  // Named internal events
  logic              tick, wrap, shadow_load;
  logic [CNT_W-1:0]  count;
  logic [DIVL_W-1:0] div_lin_a;
  logic [DIVH_W-1:0] div_shift_a;
  logic [CNT_W-1:0]  top_a, on_a, off_a;
  logic              wave;

  assign shadow_load = imm_load_q || !run_en_q || wrap;

  pwm_shadow #(.DIVL_W(DIVL_W), .DIVH_W(DIVH_W), .CNT_W(CNT_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(shadow_load),
    .div_lin_w(div_lin_q), .div_shift_w(div_shift_q),
    .top_w(top_q), .on_w(on_q), .off_w(off_q),
    .div_lin_a(div_lin_a), .div_shift_a(div_shift_a),
    .top_a(top_a), .on_a(on_a), .off_a(off_a)
  );

  pwm_prescaler #(.DIVL_W(DIVL_W), .DIVH_W(DIVH_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run_en_q),
    .div_lin(div_lin_a), .div_shift(div_shift_a), .tick(tick)
  );

  pwm_period_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run_en_q), .tick(tick),
    .top(top_a), .count(count), .wrap(wrap)
  );

  assign wave    = window_level(count, on_a, off_a);
  assign pwm_out = out_en_q && run_en_q && (wave ^ invert_q);

  // R4
  full_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en_q && run_en_q && !invert_q && (on_a == off_a)) |-> pwm_out);

  // R5
  pin_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en_q |-> !pwm_out);

  // R8
  deferred_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!imm_load_q && run_en_q && !wrap) |=> $stable(top_a) && $stable(off_a) && $stable(on_a));

  // R6
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en_q |=> (count == '0));
endmodule

// File: tb/pwm_prescaled_channel_test.sv
module pwm_prescaled_channel_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [31:0] wr_data = '0;
  logic        pwm_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  pwm_prescaled_channel uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out)
  );

  function automatic logic [31:0] ctl(input bit imm, input bit run, input bit inv,
                                      input bit oen, input int s, input int n);
    logic [31:0] w;
    w = '0;
    w[17] = imm; w[16] = run; w[14] = inv; w[12] = oen;
    w[11:8] = 4'(s); w[7:0] = 8'(n);
    return w;
  endfunction

  function automatic logic [31:0] tim(input int top, input int off_pt, input int on_pt);
    return {8'(top), 8'h00, 8'(off_pt), 8'(on_pt)};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input bit addr, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = addr; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Configure while idle, then start: returns at first sample with count 0
  task automatic start(input bit imm, input int s, input int n, input logic [31:0] t);
    put(1'b0, ctl(imm, 1'b0, 1'b0, 1'b1, s, n));
    put(1'b1, t);
    put(1'b0, ctl(imm, 1'b1, 1'b0, 1'b1, s, n));
  endtask

  task automatic run_len(input logic lvl, output int n);
    n = 0;
    while (pwm_out == lvl && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic hold_low(input string req, input int len);
    int bad;
    bad = 0;
    for (int i = 0; i < len; i++) begin
      if (pwm_out !== 1'b0) bad++;
      @(negedge clk);
    end
    check(req, bad, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 out after reset", int'(pwm_out), 0);
    hold_low("R1 stays low", 20);
  endtask

  task automatic t_period;
    int n;
    // N=1,S=1 -> 4 cycles per count, P=9, window 2..4
    start(1'b0, 1, 1, tim(9, 5, 2));
    run_len(1'b0, n);
    run_len(1'b1, n); check("R2 R3 high run", n, 12);
    run_len(1'b0, n); check("R2 R3 low run", n, 28);
    // N=0,S=3 -> 8 cycles per count, P=1, window 0..0
    start(1'b0, 3, 0, tim(1, 1, 0));
    run_len(1'b1, n);
    run_len(1'b0, n); check("R2 shift low run", n, 8);
    run_len(1'b1, n); check("R2 shift high run", n, 8);
  endtask

  task automatic t_wrapwin;
    int n;
    // on 7, off 3, P=9: high counts 7,8,9,0,1,2
    start(1'b0, 1, 1, tim(9, 3, 7));
    run_len(1'b1, n);
    run_len(1'b0, n); check("R3 wrapped low run", n, 16);
    run_len(1'b1, n); check("R3 wrapped high run", n, 24);
  endtask

  task automatic t_full;
    int lows;
    start(1'b0, 0, 0, tim(9, 4, 4));
    lows = 0;
    for (int i = 0; i < 60; i++) begin
      if (pwm_out !== 1'b1) lows++;
      @(negedge clk);
    end
    check("R4 full duty low samples", lows, 0);
  endtask

  task automatic t_invert;
    start(1'b0, 0, 0, tim(9, 4, 4));
    check("R7 before invert", int'(pwm_out), 1);
    put(1'b0, ctl(1'b0, 1'b1, 1'b1, 1'b1, 0, 0));
    check("R7 inverted next sample", int'(pwm_out), 0);
    put(1'b0, ctl(1'b0, 1'b1, 1'b0, 1'b1, 0, 0));
    check("R7 restored next sample", int'(pwm_out), 1);
  endtask

  task automatic t_outen;
    start(1'b0, 0, 0, tim(9, 4, 4));
    put(1'b0, ctl(1'b0, 1'b1, 1'b0, 1'b0, 0, 0));
    check("R5 low right after clear", int'(pwm_out), 0);
    hold_low("R5 stays low", 50);
    put(1'b0, ctl(1'b0, 1'b1, 1'b1, 1'b0, 0, 0));
    hold_low("R5 low with invert", 20);
  endtask

  task automatic t_runen;
    int n;
    start(1'b0, 0, 0, tim(9, 4, 4));
    put(1'b0, ctl(1'b0, 1'b0, 1'b0, 1'b1, 0, 0));
    check("R6 low right after stop", int'(pwm_out), 0);
    put(1'b1, tim(3, 1, 0));
    hold_low("R6 idle low", 40);
    put(1'b0, ctl(1'b0, 1'b1, 1'b0, 1'b1, 0, 0));
    check("R6 count 0 high at restart", int'(pwm_out), 1);
    run_len(1'b1, n); check("R6 first high", n, 1);
    run_len(1'b0, n); check("R6 new low run", n, 3);
    run_len(1'b1, n); check("R6 new high run", n, 1);
  endtask

  task automatic t_reload(input bit imm, input string req, input int h1, input int l1);
    int n;
    start(imm, 0, 0, tim(99, 50, 0));
    repeat (9) @(negedge clk);
    put(1'b1, tim(99, 20, 0));
    run_len(1'b1, n); check({req, " rest of pulse"}, n, h1);
    run_len(1'b0, n); check({req, " low run"}, n, l1);
    run_len(1'b1, n); check({req, " next pulse"}, n, 20);
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected<=200000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 out in reset", int'(pwm_out), 0);
    rst_n = 1'b1;
    t_reset();
    t_period();
    t_wrapwin();
    t_full();
    t_invert();
    t_outen();
    t_runen();
    t_reload(1'b0, "R8", 39, 50);
    t_reload(1'b1, "R9", 9, 80);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule